// File: doc/BRIEF.md
# Doze and RC Postscaler Clock Ratio Unit

This block holds a 16-bit clock-ratio control register and turns it into clock enables for the clock tree. Real gated clocks are built elsewhere. The first enable, `rcEn`, divides the fast RC clock by a power of two. It feeds the postscaled-RC source mode, and the base clock stands in for the RC clock. The second pair of enables relates the CPU to the peripherals. `periphEn` is asserted on every base cycle. `cpuEn` is asserted once every N base cycles when doze is active, where N is set by a 3-bit code.

Software writes the register through a simple write strobe and reads it back on a continuous read port. An interrupt pulse can drop the part out of doze when the recovery bit is armed. The unit also reports whether the present postscaler setting is allowed to feed the RC multiplier mode.

The register fields are:
- bit 15: recovery arm.
- bits 14:12: doze ratio code.
- bit 11: doze on.
- bits 10:8: RC postscaler code.
- bits 7:0: always read as zero.

A changed code is applied only when the running divider reaches its terminal count, so no shortened enable interval is ever produced.

Top module: `clkRatioUnit`

## Requirements
- R1: After a synchronous reset, the readback is 0x0100. This means the RC code is 001 (/2) and doze is off, so the CPU:peripheral ratio is 1:1. Both dividers restart at their terminal count, so `rcEn` and `cpuEn` are high in the first cycle after reset.
- R2: RC code in bits 10:8 selects the `rcEn` period in base cycles: 000→1, 001→2, 010→4, 011→8, 100→16, 101→32, 110→64, 111→256.
- R3: When bit 11 is set, the doze code in bits 14:12 gives a `cpuEn` period of 2^code base cycles (000→1 up to 111→128).
- R4: When bit 11 is clear, `cpuEn` runs at 1:1 (period 1) whatever the doze code.
- R5: If `irqPulse` is high while bit 15 reads 1, bit 11 reads 0 after that clock edge. This holds even if a write setting bit 11 happens in the same cycle. The CPU then returns to 1:1.
- R6: If `irqPulse` is high while bit 15 reads 0, the register and the `cpuEn` period are unchanged.
- R7: A new code takes effect at the first terminal count of the running divider after the write, not before. For example: a write of RC code 111 made in a cycle where `rcEn` pulses with code 011 gives an 8-cycle interval, then 256-cycle intervals.
- R8: `periphEn` is high on every cycle after reset is released.
- R9: Bits 7:0 of the readback are always zero, whatever was written to them.
- R10: `pllSrcOk` is high exactly when the RC code in the register is 000 or 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (stands in for the fast RC clock) |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Continuous register readback |
| irqPulse | input | 1 | Interrupt pulse, one cycle per event |
| rcEn | output | 1 | Divided RC clock enable |
| cpuEn | output | 1 | CPU clock enable |
| periphEn | output | 1 | Peripheral clock enable |
| pllSrcOk | output | 1 | Postscaler setting may feed the multiplier mode |

## Verification
On every cycle, the assertions check the following:
- `periphEn` stays high.
- Once a 1:1 enable is seen with a 1:1 setting, it stays 1:1.
- An armed interrupt clears doze-on.
- An unarmed interrupt without a write leaves the register alone.

Other properties span many cycles and depend on history. These include the exact period for each of the sixteen codes, the timing of a code change at the terminal count, and priority over a same-cycle write. Only the bench's cycle-by-cycle reference model and its gap-measuring scenarios show them.

// File: rtl/clkRatioPkg.sv
package clkRatioPkg;
  localparam int CODE_W = 3;
  localparam int DATA_W = 16;

  // codes handed from control to datapath
  typedef struct packed {
    logic [CODE_W-1:0] rcCode;   // RC postscaler code
    logic [CODE_W-1:0] cpuCode;  // effective doze code (0 when doze is off)
  } ratioSel_t;

  // code 111 of the RC postscaler skips /128 and selects /256
  function automatic logic [3:0] rcShift(input logic [CODE_W-1:0] code);
    return (code == 3'b111) ? 4'd8 : {1'b0, code};
  endfunction
endpackage

// File: rtl/powDivider.sv
module powDivider #(
  parameter int CNT_W = 8,
  localparam int SH_W = $clog2(CNT_W + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SH_W-1:0] shift,
  output logic            en
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;

  assign span = ({{CNT_W{1'b0}}, 1'b1} << shift) - 1'b1;
  assign en   = (cnt == '0);

  // the shift is sampled only at terminal count, so no runt interval
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (en)  cnt <= span[CNT_W-1:0];
    else          cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/clkRatioCtrl.sv
module clkRatioCtrl
  import clkRatioPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              pllSrcOk,
  output ratioSel_t         sel
);
  logic              recoverArm;
  logic [CODE_W-1:0] dozeCode;
  logic              dozeOn;
  logic [CODE_W-1:0] rcCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      recoverArm <= 1'b0;
      dozeCode   <= '0;
      dozeOn     <= 1'b0;
      rcCode     <= 3'b001;
    end else begin
      if (wrEn) begin
        recoverArm <= wrData[15];
        dozeCode   <= wrData[14:12];
        dozeOn     <= wrData[11];
        rcCode     <= wrData[10:8];
      end
      // armed interrupt wins over a same-cycle write of doze-on
      if (irqPulse && recoverArm) dozeOn <= 1'b0;
    end
  end

  assign rdData      = {recoverArm, dozeCode, dozeOn, rcCode, 8'h00};
  assign pllSrcOk    = (rcCode == 3'b000) || (rcCode == 3'b001);
  assign sel.rcCode  = rcCode;
  assign sel.cpuCode = dozeOn ? dozeCode : '0;
endmodule

// File: rtl/clkRatioPath.sv
module clkRatioPath
  import clkRatioPkg::*;
#(
  parameter int CNT_W = 8,
  localparam int SH_W = $clog2(CNT_W + 1),
  localparam int NDIV = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  ratioSel_t sel,
  output logic      rcEn,
  output logic      cpuEn,
  output logic      periphEn
);
  logic [SH_W-1:0] shifts [NDIV];
  logic [NDIV-1:0] ens;

  assign shifts[0] = SH_W'(rcShift(sel.rcCode));
  assign shifts[1] = SH_W'(sel.cpuCode);

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    powDivider #(.CNT_W(CNT_W)) i_div (
      .clk  (clk),
      .rst  (rst),
      .shift(shifts[g]),
      .en   (ens[g])
    );
  end

  assign rcEn  = ens[0];
  assign cpuEn = ens[1];

  always_ff @(posedge clk) begin
    if (rst) periphEn <= 1'b0;
    else     periphEn <= 1'b1;
  end
endmodule

// File: rtl/clkRatioUnit.sv
module clkRatioUnit
  import clkRatioPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        irqPulse,
  output logic        rcEn,
  output logic        cpuEn,
  output logic        periphEn,
  output logic        pllSrcOk
);
  ratioSel_t sel;

  clkRatioCtrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .irqPulse(irqPulse),
    .rdData  (rdData),
    .pllSrcOk(pllSrcOk),
    .sel     (sel)
  );

  clkRatioPath #(.CNT_W(CNT_W)) i_path (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .rcEn    (rcEn),
    .cpuEn   (cpuEn),
    .periphEn(periphEn)
  );
endmodule

// File: rtl/clkRatioChecker.sv
module clkRatioChecker (
  input logic        clk,
  input logic        rst,
  input logic        wrEn,
  input logic [15:0] rdData,
  input logic        irqPulse,
  input logic        rcEn,
  input logic        cpuEn,
  input logic        periphEn
);
  assert_periph_always_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> periphEn);

  assert_cpu_unity_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (cpuEn && !rdData[11]) |=> cpuEn);

  assert_rc_unity_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (rcEn && rdData[10:8] == 3'b000) |=> rcEn);

  assert_irq_clears_doze_R5: assert property (@(posedge clk) disable iff (rst)
    (irqPulse && rdData[15]) |=> !rdData[11]);

  assert_irq_unarmed_inert_R6: assert property (@(posedge clk) disable iff (rst)
    (irqPulse && !rdData[15] && !wrEn) |=> $stable(rdData));
endmodule

bind clkRatioUnit clkRatioChecker i_chk (
  .clk     (clk),
  .rst     (rst),
  .wrEn    (wrEn),
  .rdData  (rdData),
  .irqPulse(irqPulse),
  .rcEn    (rcEn),
  .cpuEn   (cpuEn),
  .periphEn(periphEn)
);

// File: tb/test_clkRatioUnit.sv
`timescale 1ns/1ps
module test_clkRatioUnit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic irqPulse = 1'b0;
  logic [15:0] rdData;
  logic rcEn, cpuEn, periphEn, pllSrcOk;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  clkRatioUnit i_clkRatioUnit (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .irqPulse(irqPulse), .rcEn(rcEn), .cpuEn(cpuEn), .periphEn(periphEn),
    .pllSrcOk(pllSrcOk)
  );

  // behavioural reference model
  int mArm, mDozeCode, mDozeOn, mRcCode, mRcCnt, mCpuCnt, mPeri;

  always @(posedge clk) begin
    int rcRatio, cpuRatio, armPre;
    if (rst) begin
      mArm = 0; mDozeCode = 0; mDozeOn = 0; mRcCode = 1;
      mRcCnt = 0; mCpuCnt = 0; mPeri = 0;
    end else begin
      rcRatio  = (mRcCode == 7) ? 256 : (1 << mRcCode);
      cpuRatio = mDozeOn ? (1 << mDozeCode) : 1;
      mRcCnt   = (mRcCnt == 0) ? rcRatio - 1 : mRcCnt - 1;
      mCpuCnt  = (mCpuCnt == 0) ? cpuRatio - 1 : mCpuCnt - 1;
      mPeri    = 1;
      armPre   = mArm;
      if (wrEn) begin
        mArm = wrData[15]; mDozeCode = wrData[14:12];
        mDozeOn = wrData[11]; mRcCode = wrData[10:8];
      end
      if (irqPulse && armPre == 1) mDozeOn = 0;
    end
    started = 1;
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      checkEq("R9 readback vs model", rdData,
              (mArm << 15) | (mDozeCode << 12) | (mDozeOn << 11) | (mRcCode << 8));
      checkEq("R2 rcEn vs model", rcEn, mRcCnt == 0);
      checkEq("R3 cpuEn vs model", cpuEn, mCpuCnt == 0);
      checkEq("R8 periphEn vs model", periphEn, mPeri);
      checkEq("R10 pllSrcOk vs model", pllSrcOk, mRcCode <= 1);
    end
  end

  task automatic writeReg(input logic [15:0] v);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic pick(input int s);
    return (s == 0) ? rcEn : cpuEn;
  endfunction

  // returns at a negedge where the selected enable is high
  task automatic gapOf(input int s, output int gap);
    @(negedge clk);
    while (!pick(s)) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!pick(s));
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 reset readback", rdData, 16'h0100);
    checkEq("R1 reset cpu 1:1", cpuEn, 1);
    gapOf(0, g); checkEq("R1 reset rc /2", g, 2);
    checkEq("R10 pll ok at /2", pllSrcOk, 1);

    // R2 every RC code
    for (int c = 0; c < 8; c++) begin
      writeReg(16'(c << 8));
      gapOf(0, g); gapOf(0, g); gapOf(0, g);
      checkEq($sformatf("R2 rc period code %0d", c), g, (c == 7) ? 256 : (1 << c));
      checkEq($sformatf("R10 pll ok code %0d", c), pllSrcOk, c <= 1);
    end

    // R3 every doze code with doze on
    for (int c = 0; c < 8; c++) begin
      writeReg(16'((c << 12) | (1 << 11)));
      gapOf(1, g); gapOf(1, g); gapOf(1, g);
      checkEq($sformatf("R3 cpu period code %0d", c), g, 1 << c);
      checkEq("R8 periph during doze", periphEn, 1);
    end

    // R4 doze code set but doze off
    writeReg(16'h5000);
    gapOf(1, g); gapOf(1, g); gapOf(1, g);
    checkEq("R4 doze off is 1:1", g, 1);

    // R5 armed interrupt
    writeReg(16'hB800);
    gapOf(1, g); checkEq("R5 doze active before irq", g, 8);
    irqPulse = 1'b1; @(negedge clk); irqPulse = 1'b0;
    checkEq("R5 bit11 cleared", rdData[11], 0);
    gapOf(1, g); gapOf(1, g);
    checkEq("R5 back to 1:1", g, 1);
    // R5 same-cycle write and interrupt: interrupt wins
    irqPulse = 1'b1; writeReg(16'hA800); irqPulse = 1'b0;
    checkEq("R5 irq wins over write", rdData, 16'hA000);

    // R6 unarmed interrupt
    writeReg(16'h2800);
    irqPulse = 1'b1; @(negedge clk); irqPulse = 1'b0;
    checkEq("R6 register unchanged", rdData, 16'h2800);
    gapOf(1, g); gapOf(1, g);
    checkEq("R6 period unchanged", g, 4);

    // R7 code change at terminal count
    writeReg(16'h0300);
    gapOf(0, g); gapOf(0, g);
    checkEq("R7 old period", g, 8);
    writeReg(16'h0700);
    g = 1;
    while (!rcEn) begin @(negedge clk); g++; end
    checkEq("R7 interval finishes old code", g, 8);
    gapOf(0, g);
    checkEq("R7 new period", g, 256);

    // R9 low byte ignored
    writeReg(16'h01FF);
    checkEq("R9 low byte zero", rdData, 16'h0100);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule